// File: doc/BRIEF.md
# Dual-Mode Deinterleaver Read-Address Generator

This block produces the read-address stream for the receive-side block deinterleaver of an OFDM link, where the coded bits of one block sit in a storage array of `ROWS` rows. Each address has the form `ROWS*c + i`, with `i` the row and `c` the column actually read. For 16-QAM and 64-QAM the column order within each row is rotated inside small column groups. The rotation depends on the row. The result undoes both permutation steps of the transmit interleaver.

A single start pulse launches one block. The block first confirms that the requested size suits the selected constellation. It does this by stepping an accumulator in units of a whole column group, so no divider is needed. It then sends out one registered address per clock, rows outermost and columns innermost. Column position comes from small group counters plus a group base that grows by addition, and the per-row rotation is a phase counter. Scaling a slot by `ROWS` is one small shift-and-add stage. There is no stored address table and no floor or modulo hardware.

Top module: `dil_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `addr_valid`, `blk_end` and `size_err` are low.
- R2: With `mode_sel` = 0 (16-QAM) the columns form pairs {2g, 2g+1}. Even rows read them in natural order and odd rows swap each pair. Every emitted address equals `ROWS*c + i`, with row `i` outer and column position inner (row 1 of a 16-row block starts 17, 1, 49, 33, 81).
- R3: With `mode_sel` = 1 (64-QAM) the columns form triples {3g, 3g+1, 3g+2}. Position o (0..2) inside a triple reads column 3g + ((o + i mod 3) mod 3). Row 1 starts 17, 33, 1, 65, 81 and row 2 starts 34, 2, 18, 82, 50.
- R4: An accepted block of N bits emits exactly N addresses, with `addr_valid` high on consecutive cycles and no gap. Together they cover every value 0..N-1 once.
- R5: `blk_end` is high on the cycle of the last address only. On the next cycle `addr_valid` is low and the block is idle.
- R6: A size `blk_bits` is accepted only if it is nonzero, no more than `MAX_BITS`, and a multiple of 2*ROWS (16-QAM) or 3*ROWS (64-QAM). Otherwise `size_err` rises and no address is emitted. `size_err` stays high until the next accepted start, which clears it.
- R7: A start while a block is being sized or emitted is ignored. `mode_sel` and `blk_bits` are sampled only at an accepted start, so changing them mid-block has no effect on the stream.
- R8: Let the start be sampled at clock edge 0, and let K = N / (group width * ROWS). The first address is valid right after edge K+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to generate one block |
| mode_sel | input | 1 | 0 = 16-QAM pairs, 1 = 64-QAM triples |
| blk_bits | input | ADDR_W+1 | Coded block size N in bits |
| addr | output | ADDR_W | Read address into the deinterleaver store |
| addr_valid | output | 1 | `addr` holds a valid address |
| blk_end | output | 1 | Marks the last address of the block |
| size_err | output | 1 | Last requested size was rejected |

## Verification
Some properties are checked on every cycle by the embedded assertions. These are the stream's local shape: valid addresses stay below the latched size, the stream has no gaps, the end marker comes only with a valid address and is followed by silence, and a size error never coexists with output. They also check that the row-phase counter always equals the row index modulo the group width, that the latched configuration is stable while addresses flow, and that an accepted size is a true multiple of the group span. Only the bench scenarios can show the full ordering against a separately written model of the two permutation steps, the permutation coverage of a whole block, the exact start-to-first-address latency, and that a mid-block start or input change leaves the stream unchanged.

// File: rtl/dil_pkg.sv
package dil_pkg;

  typedef enum logic {
    MOD_QAM16 = 1'b0,
    MOD_QAM64 = 1'b1
  } mod_e;

  // Number of columns in one rotation group.
  function automatic logic [1:0] group_len(mod_e m);
    return (m == MOD_QAM64) ? 2'd3 : 2'd2;
  endfunction

  // Column slot read at position o of a group, for row phase r.
  function automatic logic [1:0] rot_slot(mod_e m, logic [1:0] o, logic [1:0] r);
    logic [2:0] s;
    if (m == MOD_QAM16) begin
      return {1'b0, o[0] ^ r[0]};
    end
    s = {1'b0, o} + {1'b0, r};
    return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
  endfunction

  // Row phase after advancing by one row (row index mod group length).
  function automatic logic [1:0] next_phase(mod_e m, logic [1:0] r);
    return (r == group_len(m) - 2'd1) ? 2'd0 : r + 2'd1;
  endfunction

endpackage

// File: rtl/dil_size_check.sv
module dil_size_check
  import dil_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int ADDR_W   = 11,
  parameter int MAX_BITS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  mod_e              mode_i,
  input  logic [ADDR_W:0]   nbits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output mod_e              mode_o,
  output logic [ADDR_W:0]   nbits_o
);

  localparam int N_W   = ADDR_W + 1;
  localparam int ACC_W = ADDR_W + 3;
  localparam logic [ACC_W-1:0] STEP16 = ACC_W'(2 * ROWS);
  localparam logic [ACC_W-1:0] STEP64 = ACC_W'(3 * ROWS);
  localparam logic [N_W-1:0]   MAX_N  = N_W'(MAX_BITS);

  logic             busy_q;
  logic [ACC_W-1:0] acc_q;
  mod_e             mode_q;
  logic [N_W-1:0]   nbits_q;

  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] target_w;
  logic             reached_w;
  logic             exact_w;
  logic             ok_w;

  assign step_w    = (mode_q == MOD_QAM64) ? STEP64 : STEP16;
  assign target_w  = {2'b00, nbits_q};
  assign reached_w = busy_q && (acc_q >= target_w);
  assign exact_w   = (acc_q == target_w);
  assign ok_w      = reached_w && exact_w && (nbits_q != '0) && (nbits_q <= MAX_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      acc_q   <= '0;
      mode_q  <= MOD_QAM16;
      nbits_q <= '0;
    end else if (go) begin
      busy_q  <= 1'b1;
      acc_q   <= '0;
      mode_q  <= mode_i;
      nbits_q <= nbits_i;
    end else if (busy_q) begin
      if (reached_w) begin
        busy_q <= 1'b0;
      end else begin
        acc_q <= acc_q + step_w;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = reached_w;
  assign ok_o    = ok_w;
  assign mode_o  = mode_q;
  assign nbits_o = nbits_q;

  // An accepted size is a whole number of column groups (R6).
  assert_ok_is_group_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_w |-> ((int'(nbits_q) % int'(step_w)) == 0));

  // The scan always terminates with a verdict before the accumulator passes N (R6).
  assert_scan_no_overshoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !reached_w) |=> (busy_q && (acc_q < target_w + step_w)));

endmodule

// File: rtl/dil_index_walk.sv
module dil_index_walk
  import dil_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int ADDR_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  mod_e                        mode_i,
  input  logic [ADDR_W:0]             nbits_i,
  output logic                        active_o,
  output logic [$clog2(ROWS)-1:0]     row_o,
  output logic [1:0]                  slot_o,
  output logic [ADDR_W:0]             gbase_o,
  output logic                        last_o
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int N_W   = ADDR_W + 1;
  localparam logic [N_W-1:0]   GSTEP16  = N_W'(2 * ROWS);
  localparam logic [N_W-1:0]   GSTEP64  = N_W'(3 * ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             active_q;
  logic [ROW_W-1:0] row_q;
  logic [1:0]       phase_q;
  logic [1:0]       pos_q;
  logic [N_W-1:0]   gbase_q;

  logic [1:0]       glen_w;
  logic [N_W-1:0]   gstep_w;
  logic [N_W:0]     gnext_w;
  logic             group_end_w;
  logic             row_end_w;
  logic             last_w;

  assign glen_w      = group_len(mode_i);
  assign gstep_w     = (mode_i == MOD_QAM64) ? GSTEP64 : GSTEP16;
  assign gnext_w     = {1'b0, gbase_q} + {1'b0, gstep_w};
  assign group_end_w = active_q && (pos_q == glen_w - 2'd1);
  assign row_end_w   = group_end_w && (gnext_w == {1'b0, nbits_i});
  assign last_w      = row_end_w && (row_q == LAST_ROW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      phase_q  <= 2'd0;
      pos_q    <= 2'd0;
      gbase_q  <= '0;
    end else if (launch) begin
      active_q <= 1'b1;
      row_q    <= '0;
      phase_q  <= 2'd0;
      pos_q    <= 2'd0;
      gbase_q  <= '0;
    end else if (active_q) begin
      if (!group_end_w) begin
        pos_q <= pos_q + 2'd1;
      end else begin
        pos_q <= 2'd0;
        if (row_end_w) begin
          gbase_q <= '0;
          row_q   <= row_q + 1'b1;
          phase_q <= next_phase(mode_i, phase_q);
          if (last_w) begin
            active_q <= 1'b0;
          end
        end else begin
          gbase_q <= gnext_w[N_W-1:0];
        end
      end
    end
  end

  assign active_o = active_q;
  assign row_o    = row_q;
  assign slot_o   = rot_slot(mode_i, pos_q, phase_q);
  assign gbase_o  = gbase_q;
  assign last_o   = last_w;

  // The incremental row phase always equals row mod group length (R2, R3).
  assert_phase_tracks_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (int'(phase_q) == (int'(row_q) % int'(glen_w))));

  // The group base never leaves the block (R4).
  assert_gbase_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (gbase_q < nbits_i));

endmodule

// File: rtl/dil_addr_form.sv
module dil_addr_form
  import dil_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int ADDR_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active_i,
  input  logic                     last_i,
  input  logic [$clog2(ROWS)-1:0]  row_i,
  input  logic [1:0]               slot_i,
  input  logic [ADDR_W:0]          gbase_i,
  input  logic [ADDR_W:0]          nbits_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     valid_o,
  output logic                     end_o
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int N_W   = ADDR_W + 1;
  localparam logic [N_W-1:0] SCALE1 = N_W'(ROWS);
  localparam logic [N_W-1:0] SCALE2 = N_W'(2 * ROWS);

  logic [N_W-1:0] slot_off_w;
  logic [N_W-1:0] sum_w;
  logic [ADDR_W-1:0] addr_q;
  logic valid_q;
  logic end_q;

  // Slot times ROWS: a constant shift-and-add, no general multiplier.
  always_comb begin
    unique case (slot_i)
      2'd0:    slot_off_w = '0;
      2'd1:    slot_off_w = SCALE1;
      default: slot_off_w = SCALE2;
    endcase
  end

  assign sum_w = gbase_i + slot_off_w + {{(N_W-ROW_W){1'b0}}, row_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      valid_q <= active_i;
      end_q   <= active_i && last_i;
      if (active_i) begin
        addr_q <= sum_w[ADDR_W-1:0];
      end
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;
  assign end_o   = end_q;

  // Every emitted address lies inside the block (R4).
  assert_addr_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ({1'b0, addr_q} < nbits_i));

endmodule

// File: rtl/dil_addr_gen.sv
module dil_addr_gen
  import dil_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int ADDR_W   = 11,
  parameter int MAX_BITS = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_sel,
  input  logic [ADDR_W:0]   blk_bits,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic              blk_end,
  output logic              size_err
);

  localparam int ROW_W = $clog2(ROWS);

  logic              sz_busy_w;
  logic              sz_done_w;
  logic              sz_ok_w;
  mod_e              cfg_mode_w;
  logic [ADDR_W:0]   cfg_bits_w;

  logic              walk_active_w;
  logic [ROW_W-1:0]  walk_row_w;
  logic [1:0]        walk_slot_w;
  logic [ADDR_W:0]   walk_gbase_w;
  logic              walk_last_w;

  logic idle_w;
  logic accept_w;
  logic launch_w;
  logic reject_w;
  logic err_q;

  assign idle_w   = !sz_busy_w && !walk_active_w;
  assign accept_w = start && idle_w;
  assign launch_w = sz_done_w && sz_ok_w;
  assign reject_w = sz_done_w && !sz_ok_w;

  dil_size_check #(.ROWS(ROWS), .ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS)) u_size (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (accept_w),
    .mode_i  (mod_e'(mode_sel)),
    .nbits_i (blk_bits),
    .busy_o  (sz_busy_w),
    .done_o  (sz_done_w),
    .ok_o    (sz_ok_w),
    .mode_o  (cfg_mode_w),
    .nbits_o (cfg_bits_w)
  );

  dil_index_walk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch_w),
    .mode_i   (cfg_mode_w),
    .nbits_i  (cfg_bits_w),
    .active_o (walk_active_w),
    .row_o    (walk_row_w),
    .slot_o   (walk_slot_w),
    .gbase_o  (walk_gbase_w),
    .last_o   (walk_last_w)
  );

  dil_addr_form #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_form (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (walk_active_w),
    .last_i   (walk_last_w),
    .row_i    (walk_row_w),
    .slot_i   (walk_slot_w),
    .gbase_i  (walk_gbase_w),
    .nbits_i  (cfg_bits_w),
    .addr_o   (addr),
    .valid_o  (addr_valid),
    .end_o    (blk_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (accept_w) begin
      err_q <= 1'b0;
    end else if (reject_w) begin
      err_q <= 1'b1;
    end
  end

  assign size_err = err_q;

  // The end marker rides on a valid address (R5).
  assert_end_has_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> addr_valid);

  // After the end marker the output goes quiet (R5).
  assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !addr_valid);

  // The stream has no holes until the end marker (R4).
  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !blk_end) |=> addr_valid);

  // A rejected size produces no address (R6).
  assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !addr_valid);

  // The latched configuration holds while the walk runs (R7).
  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active_w |=> ($stable(cfg_mode_w) && $stable(cfg_bits_w)));

  // Sizing and walking never overlap (R7).
  assert_phases_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sz_busy_w && walk_active_w));

endmodule

// File: tb/test_dil_addr_gen.sv
module test_dil_addr_gen;

  localparam int D      = 16;
  localparam int AW     = 11;
  localparam int MAXB   = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode_sel = 1'b0;
  logic [AW:0]   blk_bits = '0;
  logic [AW-1:0] addr;
  logic          addr_valid;
  logic          blk_end;
  logic          size_err;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  dil_addr_gen #(.ROWS(D), .ADDR_W(AW), .MAX_BITS(MAXB)) i_dil_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_sel   (mode_sel),
    .blk_bits   (blk_bits),
    .addr       (addr),
    .addr_valid (addr_valid),
    .blk_end    (blk_end),
    .size_err   (size_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model: column read at position j of row i, written per column index.
  function automatic int model_addr(bit m, int i, int j);
    int width = m ? 3 : 2;
    int pos   = j % width;
    int first = j - pos;
    int col;
    if (m) col = first + ((pos + (i % 3)) % 3);
    else   col = first + (pos ^ (i % 2));
    return D * col + i;
  endfunction

  task automatic run_block(input bit m, input int n, input bit poke, input string req);
    int width = m ? 3 : 2;
    int k = n / (width * D);
    int cnt = 0;
    int got_a[MAXB + 4];
    bit got_v[MAXB + 4];
    bit got_e[MAXB + 4];
    bit seen[MAXB];
    int bad_seq = 0;
    int bad_idx = -1;
    int bad_act = 0;
    int bad_exp = 0;
    int dup = 0;
    int end_cnt = 0;
    int end_pos = -1;
    int gaps = 0;
    int tail_v = 0;
    @(negedge clk);
    mode_sel = m;
    blk_bits = (AW+1)'(n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!addr_valid && cnt < 400) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    check(cnt == k + 2, "R8", "first address latency", cnt, k + 2);
    check(size_err == 1'b0, "R6", "size_err clear on good start", int'(size_err), 0);
    for (int idx = 0; idx < n + 3; idx++) begin
      got_v[idx] = addr_valid;
      got_e[idx] = blk_end;
      got_a[idx] = int'(addr);
      if (poke && idx == n / 2) begin
        start = 1'b1;
        mode_sel = ~m;
        blk_bits = 12'd96;
      end else if (poke && idx == n / 2 + 1) begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    for (int idx = 0; idx < n; idx++) begin
      int e = model_addr(m, idx / (n / D), idx % (n / D));
      if (!got_v[idx]) gaps++;
      if (got_a[idx] != e && bad_idx < 0) begin
        bad_idx = idx; bad_act = got_a[idx]; bad_exp = e;
      end
      if (got_a[idx] != e) bad_seq++;
      if (got_a[idx] < MAXB) begin
        if (seen[got_a[idx]]) dup++;
        seen[got_a[idx]] = 1'b1;
      end
    end
    for (int idx = 0; idx < n + 3; idx++) begin
      if (got_e[idx]) begin
        end_cnt++;
        end_pos = idx;
      end
    end
    for (int idx = n; idx < n + 3; idx++) if (got_v[idx]) tail_v++;
    check(bad_seq == 0, req, $sformatf("address order, first bad index %0d", bad_idx),
          bad_act, bad_exp);
    check(gaps == 0, "R4", "valid gaps within block", gaps, 0);
    check(dup == 0, "R4", "duplicate addresses", dup, 0);
    check(end_cnt == 1 && end_pos == n - 1, "R5", "blk_end position", end_pos, n - 1);
    check(tail_v == 0, "R5", "valid after block end", tail_v, 0);
    if (poke) check(tail_v == 0 && bad_seq == 0, "R7", "mid-block start ignored", bad_seq, 0);
  endtask

  task automatic run_bad(input bit m, input int n, input string what);
    int seen_v = 0;
    @(negedge clk);
    mode_sel = m;
    blk_bits = (AW+1)'(n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 200; c++) begin
      if (addr_valid) seen_v++;
      @(posedge clk);
      @(negedge clk);
    end
    check(seen_v == 0, "R6", {what, " no output"}, seen_v, 0);
    check(size_err == 1'b1, "R6", {what, " size_err"}, int'(size_err), 1);
  endtask

  task automatic run_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!addr_valid && !blk_end && !size_err, "R1", "outputs in reset",
          int'({addr_valid, blk_end, size_err}), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!addr_valid && !blk_end && !size_err, "R1", "outputs after reset",
          int'({addr_valid, blk_end, size_err}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    run_reset();
    run_block(1'b0, 96,   1'b0, "R2");
    run_block(1'b1, 96,   1'b0, "R3");
    run_block(1'b0, 2048, 1'b0, "R2");
    run_block(1'b1, 2016, 1'b0, "R3");
    run_block(1'b1, 576,  1'b1, "R3");
    run_block(1'b0, 384,  1'b1, "R2");
    run_bad(1'b1, 128,  "R6 triple mismatch");
    run_block(1'b1, 48,   1'b0, "R3");
    run_bad(1'b0, 100,  "R6 not row multiple");
    run_bad(1'b0, 0,    "R6 zero size");
    run_bad(1'b0, 2080, "R6 above maximum");
    run_block(1'b0, 32,   1'b0, "R2");
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule